// File: doc/BRIEF.md
# Descrambler Lock Confidence Counter

This block decides whether a self-synchronising cell descrambler has lock. After each received cell, the descrambler reports whether its prediction of the cell header check was right. The block takes that per-cell result as a valid strobe plus a good/bad flag. It keeps a 4-bit up/down confidence counter and one lock state bit. The counter counts toward the current state's exit threshold. Out of lock, good predictions count up and bad ones count down. In lock, bad predictions count up and good ones count down. A single stray result therefore costs one step and does not restart the whole count.

The two thresholds sit in one 8-bit read/write configuration register. The upper nibble is the lose threshold and the lower nibble is the gain threshold. A write-protect input blocks writes to this register. The lock bit and the live counter value come out as ports.

Top module: `dsl_lock_monitor`

## Requirements
- R1: Reset forces the block out of lock, the counter to 0, and the configuration register to 0x88, which makes both thresholds 8.
- R2: When `cfg_wr` is high and `cfg_wlock` is low, the register takes `cfg_wdata` at the clock edge, and `cfg_rdata` shows the new value from the next cycle. Bits [7:4] are the lose threshold and bits [3:0] are the gain threshold.
- R3: When `cfg_wlock` is high, a write has no effect, and `cfg_rdata` keeps its previous value.
- R4: Out of lock, a strobe with `pred_good`=1 raises the counter by one, and a strobe with `pred_good`=0 lowers it by one.
- R5: In lock, a strobe with `pred_good`=0 raises the counter by one, and a strobe with `pred_good`=1 lowers it by one.
- R6: A decrement at a count of 0 leaves the counter at 0. The counter saturates at 15.
- R7: Out of lock, if the updated count is greater than or equal to the gain threshold, `desc_locked` becomes 1 and the counter clears to 0 at the same edge.
- R8: In lock, if the updated count is greater than or equal to the lose threshold, `desc_locked` becomes 0 and the counter clears to 0 at the same edge.
- R9: A cycle without `pred_valid` leaves the counter and the lock state unchanged.
- R10: A threshold of 0 makes every strobe in the matching state change the lock state, whether the prediction was good or bad.
- R11: The threshold comparison inside a strobe uses the register value that was held before that edge. A write in the same cycle applies only to later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the threshold register |
| cfg_wlock | input | 1 | Write protect; when high, writes are ignored |
| cfg_wdata | input | 8 | Write data: [7:4] lose threshold, [3:0] gain threshold |
| cfg_rdata | output | 8 | Current threshold register contents |
| pred_valid | input | 1 | One per cell: a prediction result is present |
| pred_good | input | 1 | 1 = prediction correct, 0 = incorrect |
| desc_locked | output | 1 | 1 while the descrambler is judged locked |
| conf_cnt | output | 4 | Live confidence counter value |

## Verification
The main table walks the counter through several strobe patterns.

- Runs of good results out of lock show the count-up direction and check that the gain edge is reached at exactly the threshold.
- Alternating good and bad results separate a true up/down counter from a consecutive-event counter.
- Repeated bad results at a count of 0 expose a missing floor.
- Bad results in lock confirm that the count direction flips with the lock state.
- Zero thresholds show the comparison is greater-than-or-equal rather than strictly greater.
- A threshold of 15 shows that the gain edge comes on the fifteenth good result and not one early.
- A write issued together with a strobe separates old-threshold from new-threshold comparison.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    localparam int CNT_W  = 4;
    localparam int THR_W  = 4;
    localparam int CFG_W  = 2 * THR_W;
    localparam int CMP_W  = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_SYNC = 1'b1
    } lock_st_t;

    typedef struct packed {
        logic [THR_W-1:0] lose_thr;
        logic [THR_W-1:0] gain_thr;
    } thr_cfg_t;

    typedef struct packed {
        logic             valid;
        logic             good;
    } pred_t;

    function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                  input logic             up);
        logic [CNT_W-1:0] res;
        if (up) begin
            res = (cur == CNT_MAX) ? cur : cur + CNT_W'(1);
        end else begin
            res = (cur == '0) ? cur : cur - CNT_W'(1);
        end
        return res;
    endfunction

    function automatic logic reaches(input logic [CNT_W-1:0] cnt,
                                     input logic [THR_W-1:0] thr);
        return CMP_W'(cnt) >= CMP_W'(thr);
    endfunction

endpackage

// File: rtl/dsl_cfg_reg.sv
module dsl_cfg_reg
    import dsl_pkg::*;
#(
    parameter logic [THR_W-1:0] RST_LOSE = THR_W'(8),
    parameter logic [THR_W-1:0] RST_GAIN = THR_W'(8)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_wlock,
    input  logic [CFG_W-1:0] cfg_wdata,
    output thr_cfg_t         cfg_q
);

    logic wr_ok;
    assign wr_ok = cfg_wr & ~cfg_wlock;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.lose_thr <= RST_LOSE;
            cfg_q.gain_thr <= RST_GAIN;
        end else if (wr_ok) begin
            cfg_q <= thr_cfg_t'(cfg_wdata);
        end
    end

    AST_WLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wlock) |=> $stable(cfg_q)); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_wlock) |=> (cfg_q == $past(cfg_wdata))); // R2

endmodule

// File: rtl/dsl_conf_ctr.sv
module dsl_conf_ctr
    import dsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pred_t            pred,
    input  thr_cfg_t         thr,
    output lock_st_t         st_q,
    output logic [CNT_W-1:0] cnt_q
);

    logic             dir_up;
    logic [CNT_W-1:0] stepped;
    logic [THR_W-1:0] exit_thr;
    logic             hit;

    always_comb begin
        if (st_q == ST_SYNC) begin
            dir_up   = ~pred.good;
            exit_thr = thr.lose_thr;
        end else begin
            dir_up   = pred.good;
            exit_thr = thr.gain_thr;
        end
        stepped = sat_step(cnt_q, dir_up);
        hit     = reaches(stepped, exit_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else if (pred.valid) begin
            if (hit) begin
                st_q  <= (st_q == ST_SYNC) ? ST_HUNT : ST_SYNC;
                cnt_q <= '0;
            end else begin
                cnt_q <= stepped;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pred.valid |=> ($stable(cnt_q) && $stable(st_q))); // R9

    AST_FLIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> (cnt_q == '0)); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        pred.valid |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q))
                        || (cnt_q == $past(cnt_q) + CNT_W'(1))
                        || (cnt_q == $past(cnt_q) - CNT_W'(1)))); // R4

    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (pred.valid && cnt_q == '0 && st_q == ST_HUNT && !pred.good)
        |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/dsl_lock_monitor.sv
module dsl_lock_monitor
    import dsl_pkg::*;
#(
    parameter logic [THR_W-1:0] RST_LOSE = THR_W'(8),
    parameter logic [THR_W-1:0] RST_GAIN = THR_W'(8)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_wlock,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             pred_valid,
    input  logic             pred_good,
    output logic             desc_locked,
    output logic [CNT_W-1:0] conf_cnt
);

    thr_cfg_t thr_q;
    pred_t    pred_in;
    lock_st_t st;

    assign pred_in.valid = pred_valid;
    assign pred_in.good  = pred_good;

    dsl_cfg_reg #(
        .RST_LOSE (RST_LOSE),
        .RST_GAIN (RST_GAIN)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wlock (cfg_wlock),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (thr_q)
    );

    dsl_conf_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .pred  (pred_in),
        .thr   (thr_q),
        .st_q  (st),
        .cnt_q (conf_cnt)
    );

    assign cfg_rdata   = thr_q;
    assign desc_locked = (st == ST_SYNC);

    AST_LOCK_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (desc_locked != $past(desc_locked)) |-> $past(pred_valid)); // R8

endmodule

// File: tb/dsl_lock_monitor_test.sv
module dsl_lock_monitor_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr, cfg_wlock;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       pred_valid, pred_good;
    logic       desc_locked;
    logic [3:0] conf_cnt;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dsl_lock_monitor uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wlock   (cfg_wlock),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .pred_valid  (pred_valid),
        .pred_good   (pred_good),
        .desc_locked (desc_locked),
        .conf_cnt    (conf_cnt)
    );

    typedef struct packed {
        logic       wr;
        logic       wl;
        logic [7:0] wd;
        logic       v;
        logic       g;
        logic       e_lk;
        logic [3:0] e_cnt;
        logic [7:0] e_rd;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 8'h53, 1'b0, 1'b0, 1'b0, 4'd0, 8'h53, 4'd2},  // R2 lose=5 gain=3
        '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 8'h53, 4'd3},  // R3 protected write
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd1, 8'h53, 4'd4},  // R4 good up
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0, 8'h53, 4'd4},  // R4 bad down
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0, 8'h53, 4'd6},  // R6 floor
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd0, 8'h53, 4'd9},  // R9 idle
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd1, 8'h53, 4'd4},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2, 8'h53, 4'd4},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd0, 8'h53, 4'd7},  // R7 gain at 3
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd1, 8'h53, 4'd5},  // R5 bad up
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd0, 8'h53, 4'd5},  // R5 good down
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd0, 8'h53, 4'd6},  // R6 floor in lock
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd1, 8'h53, 4'd5},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd2, 8'h53, 4'd5},
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd2, 8'h53, 4'd9},  // R9 idle in lock
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd3, 8'h53, 4'd5},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd4, 8'h53, 4'd5},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0, 8'h53, 4'd8},  // R8 lose at 5
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 4'd2},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd0, 8'h00, 4'd10}, // R10 gain thr 0
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00, 4'd10}, // R10 lose thr 0
        '{1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 1'b1, 4'd0, 8'h22, 4'd11}, // R11 old thr 0 used
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 4'd1, 8'h22, 4'd11}  // R11 new lose thr 2
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic lk, input int cnt, input int rd);
        chk(desc_locked == lk, {req, " locked"}, desc_locked, lk);
        chk(conf_cnt == 4'(cnt), {req, " count"}, conf_cnt, cnt);
        chk(cfg_rdata == 8'(rd), {req, " rdata"}, cfg_rdata, rd);
    endtask

    task automatic step(input logic wr, input logic wl, input logic [7:0] wd,
                        input logic v, input logic g);
        cfg_wr = wr; cfg_wlock = wl; cfg_wdata = wd;
        pred_valid = v; pred_good = g;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; pred_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wlock = 1'b0; cfg_wdata = '0;
        pred_valid = 1'b0; pred_good = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1", 1'b0, 0, 8'h88);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].wl, TBL[i].wd, TBL[i].v, TBL[i].g);
            check_all($sformatf("R%0d vec%0d", TBL[i].req, i),
                      TBL[i].e_lk, TBL[i].e_cnt, TBL[i].e_rd);
        end

        // R7 boundary: gain threshold 15 needs exactly fifteen good results
        step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1); // in lock -> good lowers, floor at 0
        for (int k = 0; k < 40 && desc_locked; k++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check_all("R8 unlock at 15", 1'b0, 0, 8'hFF);
        for (int k = 1; k <= 14; k++) begin
            step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        end
        check_all("R7 count 14 below 15", 1'b0, 14, 8'hFF);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        check_all("R7 lock at 15", 1'b1, 0, 8'hFF);

        // R1: reset in the middle of operation
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 mid-run reset", 1'b0, 0, 8'h88);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule